// File: doc/BRIEF.md
# Dual-clock presettable up/down counter

A four-bit counter with separate count-up and count-down inputs. A rising level on the up input adds one, and a rising level on the down input subtracts one. Each input counts only while the other input rests high. An active-high clear and an active-low parallel load from four jam inputs act at once, without waiting for a clock. A parameter chooses decade counting (0 to 9) or full binary counting (0 to 15).

The block runs on a fast system clock. Both count inputs pass through synchronizers, and the block detects their rising levels. Active-low carry and borrow flags are formed from the current value and the phase of the count input in use. Wiring carry to the next stage's up input and borrow to its down input builds a multi-digit counter with no glue logic.

Top module: `dcc_counter`

## Requirements
- R1: While clr_i is high, q_o reads 0 with no clock edge needed. The count register is also cleared and stays at 0. Clear overrides preset and counting.
- R2: While load_ni is low and clr_i is low, q_o equals jam_i with no clock edge needed, and count inputs have no effect. After load_ni returns high, the last jam value is held.
- R3: A rising level on up_i adds one, but only while dn_i is high. The new value appears on q_o at the third system-clock edge after the transition.
- R4: A rising level on dn_i subtracts one, but only while up_i is high. If both inputs rise in the same system-clock cycle, the count does not change.
- R5: With DECADE=1, counting up wraps from 9 to 0 and counting down wraps from 0 to 9. With DECADE=0, the wraps are from 15 to 0 and from 0 to 15.
- R6: With DECADE=1, a jam value from 10 to 15 is loaded exactly as given. From such a value, an up count goes to 0 and a down count subtracts one.
- R7: carry_no is low exactly when q_o equals the maximum (9 or 15) and the synchronized up level is low. The up level has the same latency as the count update.
- R8: borrow_no is low exactly when q_o equals 0 and the synchronized down level is low.
- R9: Two stages chained carry-to-up and borrow-to-down count as one two-digit counter, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the count inputs |
| rst_ni | input | 1 | Active-low system reset for the synchronizers and the count |
| clr_i | input | 1 | Active-high clear, asynchronous |
| load_ni | input | 1 | Active-low preset enable, asynchronous |
| jam_i | input | 4 | Preset value |
| up_i | input | 1 | Count-up input, counts on a rising level |
| dn_i | input | 1 | Count-down input, counts on a rising level |
| q_o | output | 4 | Current count |
| carry_no | output | 1 | Active-low carry, feeds the next stage's up input |
| borrow_no | output | 1 | Active-low borrow, feeds the next stage's down input |

## Verification
The assertions assume three things about the inputs:
- Each level on up_i and dn_i lasts at least as many system-clock cycles as there are synchronizer stages, so no transition is lost.
- Clear and preset are levels held across at least one system-clock edge.
- Both count inputs rest high when idle.

The stimulus changes inputs only just after a falling clock edge. It holds every count-input level for four to eight cycles, and it returns both count inputs high between operations. A second stage driven only by the first stage's flags shows that the flags themselves satisfy the same input assumptions.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int CNT_W = 4;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        cnt_t count;
    } ctr_regs_t;
endpackage

// File: rtl/dcc_edge_sync.sv
module dcc_edge_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_i};
        st_d.last = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pipe <= {STAGES{IDLE}};
            st_q.last <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.last;
    assign rise_o  = st_q.pipe[STAGES-1] & ~st_q.last;

    AST_RISE_SETS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> level_o); // R3
endmodule

// File: rtl/dcc_step.sv
module dcc_step
    import dcc_pkg::*;
#(
    parameter cnt_t MAX_CNT = cnt_t'(9)
) (
    input  cnt_t  count_i,
    input  step_e act_i,
    output cnt_t  count_o
);
    always_comb begin
        unique case (act_i)
            ACT_UP:   count_o = (count_i >= MAX_CNT) ? '0 : cnt_t'(count_i + 1'b1);
            ACT_DOWN: count_o = (count_i == '0) ? MAX_CNT : cnt_t'(count_i - 1'b1);
            default:  count_o = count_i;
        endcase
    end
endmodule

// File: rtl/dcc_flags.sv
module dcc_flags
    import dcc_pkg::*;
#(
    parameter cnt_t MAX_CNT = cnt_t'(9)
) (
    input  cnt_t q_i,
    input  logic up_lvl_i,
    input  logic dn_lvl_i,
    output logic carry_no,
    output logic borrow_no
);
    always_comb begin
        carry_no  = !((q_i == MAX_CNT) && !up_lvl_i);
        borrow_no = !((q_i == '0) && !dn_lvl_i);
    end
endmodule

// File: rtl/dcc_counter.sv
module dcc_counter
    import dcc_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       load_ni,
    input  logic [3:0] jam_i,
    input  logic       up_i,
    input  logic       dn_i,
    output logic [3:0] q_o,
    output logic       carry_no,
    output logic       borrow_no
);
    localparam cnt_t MAX_CNT = DECADE ? cnt_t'(9) : cnt_t'((1 << CNT_W) - 1);
    localparam int   N_IN    = 2;

    logic [N_IN-1:0] raw, rise, lvl;
    logic            up_ok, dn_ok;
    step_e           act;
    cnt_t            step_cnt;
    ctr_regs_t       r_d, r_q;

    assign raw = {dn_i, up_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        dcc_edge_sync #(
            .STAGES (SYNC_STAGES),
            .IDLE   (1'b1)
        ) i_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g])
        );
    end

    // Each direction counts only while the other input has rested high.
    assign up_ok = rise[0] & lvl[1];
    assign dn_ok = rise[1] & lvl[0];

    always_comb begin
        if (up_ok)      act = ACT_UP;
        else if (dn_ok) act = ACT_DOWN;
        else            act = ACT_HOLD;
    end

    dcc_step #(.MAX_CNT(MAX_CNT)) i_step (
        .count_i (r_q.count),
        .act_i   (act),
        .count_o (step_cnt)
    );

    always_comb begin
        r_d = r_q;
        if (!load_ni) r_d.count = jam_i;
        else          r_d.count = step_cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
        if (!rst_ni)     r_q.count <= '0;
        else if (clr_i)  r_q.count <= '0;
        else             r_q       <= r_d;
    end

    // Clear and preset reach the output without waiting for a clock edge.
    always_comb begin
        if (clr_i)         q_o = '0;
        else if (!load_ni) q_o = jam_i;
        else               q_o = r_q.count;
    end

    dcc_flags #(.MAX_CNT(MAX_CNT)) i_flags (
        .q_i       (q_o),
        .up_lvl_i  (lvl[0]),
        .dn_lvl_i  (lvl[1]),
        .carry_no  (carry_no),
        .borrow_no (borrow_no)
    );

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |-> (r_q.count == '0 && q_o == '0)); // R1
    AST_PRESET_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        !load_ni |=> (r_q.count == $past(jam_i))); // R2
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        (load_ni && !rise[0] && !rise[1]) |=> $stable(r_q.count)); // R3
    AST_WRAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        (load_ni && up_ok && r_q.count == MAX_CNT) |=> (r_q.count == '0)); // R5
    AST_WRAP_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        (load_ni && dn_ok && r_q.count == '0) |=> (r_q.count == MAX_CNT)); // R5
    AST_CARRY_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !carry_no |-> (q_o == MAX_CNT && !lvl[0])); // R7
    AST_BORROW_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !borrow_no |-> (q_o == '0 && !lvl[1])); // R8
endmodule

// File: tb/test_dcc_counter.sv
`timescale 1ns/1ps
module test_dcc_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] jam = 4'd0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic [3:0] q_d, q_b, q_h;
    logic       cy_d, bw_d, cy_b, bw_b, cy_h, bw_h;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dcc_counter #(.DECADE(1'b1)) i_dcc_counter (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_ni(load_n), .jam_i(jam),
        .up_i(up), .dn_i(dn), .q_o(q_d), .carry_no(cy_d), .borrow_no(bw_d));

    dcc_counter #(.DECADE(1'b0)) i_dcc_counter_bin (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_ni(load_n), .jam_i(jam),
        .up_i(up), .dn_i(dn), .q_o(q_b), .carry_no(cy_b), .borrow_no(bw_b));

    dcc_counter #(.DECADE(1'b1)) i_dcc_counter_hi (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_ni(1'b1), .jam_i(4'd0),
        .up_i(cy_d), .dn_i(bw_d), .q_o(q_h), .carry_no(cy_h), .borrow_no(bw_h));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: input history three samples deep, integer counts.
    int md = 0, mb = 0;
    bit u1 = 1, u2 = 1, u3 = 1, d1 = 1, d2 = 1, d3 = 1;

    function automatic int step_up(int c, int mx);
        return (c >= mx) ? 0 : c + 1;
    endfunction
    function automatic int step_dn(int c, int mx);
        return (c == 0) ? mx : c - 1;
    endfunction

    always @(posedge clk) begin
        bit go_up, go_dn;
        if (!rst_n) begin
            md = 0; mb = 0;
            u1 = 1; u2 = 1; u3 = 1; d1 = 1; d2 = 1; d3 = 1;
        end else begin
            go_up = u2 && !u3 && d3;
            go_dn = d2 && !d3 && u3;
            if (clr) begin
                md = 0; mb = 0;
            end else if (!load_n) begin
                md = jam; mb = jam;
            end else if (go_up) begin
                md = step_up(md, 9); mb = step_up(mb, 15);
            end else if (go_dn) begin
                md = step_dn(md, 9); mb = step_dn(mb, 15);
            end
            u3 = u2; u2 = u1; u1 = up;
            d3 = d2; d2 = d1; d1 = dn;
        end
    end

    // Cycle-by-cycle comparison, before inputs move.
    always @(negedge clk) begin
        int ed, eb;
        string tq;
        if (rst_n) begin
            ed = clr ? 0 : (!load_n ? int'(jam) : md);
            eb = clr ? 0 : (!load_n ? int'(jam) : mb);
            tq = clr ? "R1" : (!load_n ? "R2" : "R3");
            chk({tq, " q decade"}, q_d, ed);
            chk({tq, " q binary"}, q_b, eb);
            chk("R7 carry decade", cy_d, (ed == 9 && !u3) ? 0 : 1);
            chk("R8 borrow decade", bw_d, (ed == 0 && !d3) ? 0 : 1);
            chk("R7 carry binary", cy_b, (eb == 15 && !u3) ? 0 : 1);
            chk("R8 borrow binary", bw_b, (eb == 0 && !d3) ? 0 : 1);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask
    task automatic pulse_up();
        up = 1'b0; wait_cyc(4);
        up = 1'b1; wait_cyc(8);
    endtask
    task automatic pulse_dn();
        dn = 1'b0; wait_cyc(4);
        dn = 1'b1; wait_cyc(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk("R1 reset q", q_d, 0);
        chk("R8 reset borrow", bw_d, 1);
        rst_n = 1'b1;
        wait_cyc(3);

        // R3: three up counts
        repeat (3) pulse_up();
        chk("R3 up count decade", q_d, 3);
        chk("R3 up count binary", q_b, 3);

        // R3 gating: up edge while dn low is ignored
        dn = 1'b0; wait_cyc(6);
        pulse_up();
        chk("R3 up gated by low dn", q_d, 3);
        // R4: releasing dn with up high is a down count
        dn = 1'b1; wait_cyc(8);
        chk("R4 down count", q_d, 2);

        // R4/R8/R5: down to zero, borrow, wrap
        repeat (2) pulse_dn();
        chk("R4 reached zero", q_d, 0);
        dn = 1'b0; wait_cyc(6);
        chk("R8 borrow low at zero", bw_d, 0);
        chk("R8 borrow low binary", bw_b, 0);
        dn = 1'b1; wait_cyc(8);
        chk("R5 decade wrap down", q_d, 9);
        chk("R5 binary wrap down", q_b, 15);
        chk("R8 borrow released", bw_d, 1);

        // R7/R5: carry at maximum, wrap up
        up = 1'b0; wait_cyc(6);
        chk("R7 carry low at 9", cy_d, 0);
        chk("R7 carry low at 15", cy_b, 0);
        up = 1'b1; wait_cyc(8);
        chk("R5 decade wrap up", q_d, 0);
        chk("R5 binary wrap up", q_b, 0);
        chk("R7 carry released", cy_d, 1);

        // R4: simultaneous rises cancel
        pulse_up();
        up = 1'b0; dn = 1'b0; wait_cyc(6);
        up = 1'b1; dn = 1'b1; wait_cyc(8);
        chk("R4 simultaneous rise", q_d, 1);

        // R2: asynchronous preset, counts ignored
        @(negedge clk); #2;
        jam = 4'd12; load_n = 1'b0; #1;
        chk("R2 async preset", q_d, 12);
        pulse_up();
        chk("R2 count ignored in preset", q_d, 12);
        load_n = 1'b1; wait_cyc(3);
        chk("R2 preset held", q_d, 12);
        pulse_up();
        chk("R6 decade 12 up to 0", q_d, 0);
        chk("R6 binary 12 up to 13", q_b, 13);
        load_n = 1'b0; wait_cyc(2);
        load_n = 1'b1; wait_cyc(2);
        pulse_dn();
        chk("R6 decade 12 down to 11", q_d, 11);

        // R1: asynchronous clear beats preset and counting
        @(negedge clk); #2;
        clr = 1'b1; load_n = 1'b0; #1;
        chk("R1 async clear", q_d, 0);
        load_n = 1'b1;
        pulse_up();
        chk("R1 count ignored in clear", q_d, 0);
        clr = 1'b0; wait_cyc(8);
        chk("R1 clear held", q_d, 0);
        chk("R1 upper stage cleared", q_h, 0);

        // R9: two-digit chain
        repeat (23) pulse_up();
        chk("R9 chain up low digit", q_d, 3);
        chk("R9 chain up high digit", q_h, 2);
        repeat (5) pulse_dn();
        chk("R9 chain down low digit", q_d, 8);
        chk("R9 chain down high digit", q_h, 1);

        wait_cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule